// File: doc/BRIEF.md
# Temperature-Stepped Fan PWM Controller

This block drives a cooling fan with a pulse-width-modulated output. The period of the output is a fixed number of clocks, chosen at build time. The high time comes from a width register. In automatic operation the block sets that width to one of five quarter levels (0, 1/4, 2/4, 3/4 or the full period). It picks the level by comparing a 16-bit unsigned raw temperature code against eight programmable thresholds. Each step up has its own "rise above" limit, and each step down has its own lower "fall below" limit, so the gap between the two gives hysteresis.

A rise is not applied at once. The block first pulses a temperature-rise strobe. It then waits a settling interval, given in clock cycles as a parameter, so the fan speed can stabilise. Only after that does it apply the new width and pulse a duty-changed strobe. A drop is applied on the next edge. Software can read and write the block through a simple word-addressed port. It can write the width directly at any time. Such a write also pulses the duty-changed strobe and cancels any step that is waiting to settle. The block stays idle until software sets its run bit.

Top module: `tstep_fan_ctrl`

## Requirements
- R1: After reset the run bit (address 0, bit 0) is 0. While the run bit is 0, the PWM output stays low, the level is held at 0 and no strobe fires, whatever the temperature. Width writes still update the width register.
- R2: Address map for reads and writes. Address 0 holds the run bit. Address 1 holds the width (read/write). Address 2 holds the period: it reads back the PERIOD parameter and writes to it are ignored. Address 3 reads the live temperature code. Addresses 4+k (k = 0..3) hold the rise threshold that lifts level k to k+1, with reset value 0xFFFF. Addresses 8+k hold the fall threshold that drops level k+1 to k, with reset value 0. Unmapped addresses read 0.
- R3: While running, the output is high for min(width, PERIOD) clocks out of every PERIOD consecutive clocks. A width at or above PERIOD gives a constant high.
- R4: At level k < 4, a temperature strictly greater than rise threshold k raises a one-cycle temperature-rise strobe. An equal temperature does nothing.
- R5: Exactly SETTLE_CYC cycles after the rise strobe, the level becomes k+1. At the same time the width becomes floor(PERIOD*(k+1)/4) and the duty-changed strobe pulses once. Each request moves the level by one step only.
- R6: At level k > 0, a temperature strictly below fall threshold k-1 lowers the level by one on the next edge. The width becomes floor(PERIOD*(k-1)/4) and the duty-changed strobe fires, with no settling delay. Temperatures between the limits hold the level.
- R7: A width write while running pulses the duty-changed strobe in the following cycle, and the written value reads back.
- R8: A width write during the settling interval cancels the pending step. The same holds for a write that lands in the cycle the interval expires. The written width is kept and the strobe fires only once.
- R9: The two strobes never fire in the same cycle, and the rise strobe never fires in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_code | input | TW | Raw unsigned temperature code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | DW | Register read data, combinational from rd_addr |
| pwm_o | output | 1 | Fan PWM output |
| ev_temp_rise_o | output | 1 | One-cycle strobe when a level increase is requested |
| ev_pwm_chg_o | output | 1 | One-cycle strobe when a new width takes effect |

## Verification
Two functions can fall in the same cycle: a software width write and the expiry of a pending hardware step. The bench provokes this by raising the temperature and then counting exactly SETTLE_CYC falling edges, so that the write lands on the very edge where the interval runs out. A second case puts the write a few cycles into the interval. In both cases the software value must read back as the width, only one duty-changed strobe may appear, and no level change may follow.

// File: rtl/tstep_fan_pkg.sv
package tstep_fan_pkg;
    localparam int AW    = 4;
    localparam int NSTEP = 4;
    localparam int LVW   = $clog2(NSTEP + 1);

    localparam logic [AW-1:0] ADR_RUN    = 4'd0;
    localparam logic [AW-1:0] ADR_WIDTH  = 4'd1;
    localparam logic [AW-1:0] ADR_PERIOD = 4'd2;
    localparam logic [AW-1:0] ADR_TEMP   = 4'd3;
    localparam logic [AW-1:0] ADR_RISE0  = 4'd4;
    localparam logic [AW-1:0] ADR_FALL0  = 4'd8;

    typedef logic [LVW-1:0] level_t;
endpackage

// File: rtl/tstep_fan_cfg.sv
module tstep_fan_cfg
    import tstep_fan_pkg::*;
#(
    parameter int DW     = 16,
    parameter int TW     = 16,
    parameter int PERIOD = 2500
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [TW-1:0]            wr_data,
    input  logic [AW-1:0]            rd_addr,
    input  logic [DW-1:0]            width_i,
    input  logic [TW-1:0]            temp_i,
    output logic                     run_o,
    output logic [NSTEP-1:0][TW-1:0] rise_thr_o,
    output logic [NSTEP-1:0][TW-1:0] fall_thr_o,
    output logic                     width_wr_o,
    output logic [DW-1:0]            rd_data_o
);
    typedef struct packed {
        logic                     run;
        logic [NSTEP-1:0][TW-1:0] rise;
        logic [NSTEP-1:0][TW-1:0] fall;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_addr == ADR_RUN) cfg_d.run = wr_data[0];
            for (int k = 0; k < NSTEP; k++) begin
                if (wr_addr == ADR_RISE0 + AW'(k)) cfg_d.rise[k] = wr_data;
                if (wr_addr == ADR_FALL0 + AW'(k)) cfg_d.fall[k] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.run  <= 1'b0;
            cfg_q.rise <= '1;
            cfg_q.fall <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_addr)
            ADR_RUN:    rd_data_o = DW'(cfg_q.run);
            ADR_WIDTH:  rd_data_o = width_i;
            ADR_PERIOD: rd_data_o = DW'(PERIOD);
            ADR_TEMP:   rd_data_o = DW'(temp_i);
            default:    ;
        endcase
        for (int k = 0; k < NSTEP; k++) begin
            if (rd_addr == ADR_RISE0 + AW'(k)) rd_data_o = DW'(cfg_q.rise[k]);
            if (rd_addr == ADR_FALL0 + AW'(k)) rd_data_o = DW'(cfg_q.fall[k]);
        end
    end

    assign run_o      = cfg_q.run;
    assign rise_thr_o = cfg_q.rise;
    assign fall_thr_o = cfg_q.fall;
    assign width_wr_o = wr_en && (wr_addr == ADR_WIDTH);
endmodule

// File: rtl/tstep_fan_step.sv
module tstep_fan_step
    import tstep_fan_pkg::*;
#(
    parameter int DW         = 16,
    parameter int TW         = 16,
    parameter int PERIOD     = 2500,
    parameter int SETTLE_CYC = 250_000_000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_i,
    input  logic [TW-1:0]            temp_i,
    input  logic [NSTEP-1:0][TW-1:0] rise_thr_i,
    input  logic [NSTEP-1:0][TW-1:0] fall_thr_i,
    input  logic                     sw_wr_i,
    input  logic [DW-1:0]            sw_data_i,
    output logic [DW-1:0]            width_o,
    output level_t                   level_o,
    output logic                     ev_rise_o,
    output logic                     ev_chg_o
);
    localparam int SCW = $clog2(SETTLE_CYC + 1);
    localparam int LW  = $clog2(NSTEP);

    typedef struct packed {
        level_t         level;
        logic           pend;
        logic [SCW-1:0] sc;
        logic [DW-1:0]  width;
        logic           ev_rise;
        logic           ev_chg;
    } st_t;

    st_t st_d, st_q;

    logic [NSTEP-1:0] up_hit, dn_hit;
    logic             want_up, want_dn;

    for (genvar k = 0; k < NSTEP; k++) begin : g_cmp
        assign up_hit[k] = temp_i > rise_thr_i[k];
        assign dn_hit[k] = temp_i < fall_thr_i[k];
    end

    function automatic logic [DW-1:0] step_width(input level_t lv);
        return DW'((PERIOD * int'(lv)) / NSTEP);
    endfunction

    assign want_up = (st_q.level < LVW'(NSTEP)) && up_hit[LW'(st_q.level)];
    assign want_dn = (st_q.level != '0) && dn_hit[LW'(st_q.level - LVW'(1))];

    always_comb begin
        st_d         = st_q;
        st_d.ev_rise = 1'b0;
        st_d.ev_chg  = 1'b0;
        if (!run_i) begin
            st_d.level = '0;
            st_d.pend  = 1'b0;
            st_d.sc    = '0;
            if (sw_wr_i) st_d.width = sw_data_i;
        end else if (sw_wr_i) begin
            st_d.width  = sw_data_i;
            st_d.pend   = 1'b0;
            st_d.sc     = '0;
            st_d.ev_chg = 1'b1;
        end else if (st_q.pend) begin
            if (st_q.sc == SCW'(1)) begin
                st_d.level  = st_q.level + LVW'(1);
                st_d.width  = step_width(st_q.level + LVW'(1));
                st_d.pend   = 1'b0;
                st_d.sc     = '0;
                st_d.ev_chg = 1'b1;
            end else begin
                st_d.sc = st_q.sc - SCW'(1);
            end
        end else if (want_up) begin
            st_d.pend    = 1'b1;
            st_d.sc      = SCW'(SETTLE_CYC);
            st_d.ev_rise = 1'b1;
        end else if (want_dn) begin
            st_d.level  = st_q.level - LVW'(1);
            st_d.width  = step_width(st_q.level - LVW'(1));
            st_d.ev_chg = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign width_o   = st_q.width;
    assign level_o   = st_q.level;
    assign ev_rise_o = st_q.ev_rise;
    assign ev_chg_o  = st_q.ev_chg;
endmodule

// File: rtl/tstep_fan_pwm.sv
module tstep_fan_pwm #(
    parameter int DW     = 16,
    parameter int PERIOD = 2500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [DW-1:0] width_i,
    output logic          pwm_o
);
    localparam int CW = $clog2(PERIOD);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pw_t;

    pw_t pw_d, pw_q;

    always_comb begin
        pw_d = pw_q;
        if (!run_i || pw_q.cnt == CW'(PERIOD - 1)) pw_d.cnt = '0;
        else                                       pw_d.cnt = pw_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pw_q <= '0;
        else        pw_q <= pw_d;
    end

    assign pwm_o = run_i && (DW'(pw_q.cnt) < width_i);
endmodule

// File: rtl/tstep_fan_ctrl.sv
module tstep_fan_ctrl
    import tstep_fan_pkg::*;
#(
    parameter int DW         = 16,
    parameter int TW         = 16,
    parameter int PERIOD     = 2500,
    parameter int SETTLE_CYC = 250_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp_code,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          pwm_o,
    output logic          ev_temp_rise_o,
    output logic          ev_pwm_chg_o
);
    logic                     run_w;
    logic [NSTEP-1:0][TW-1:0] rise_w, fall_w;
    logic                     width_wr_w;
    logic [DW-1:0]            width_w;
    level_t                   level_w;

    tstep_fan_cfg #(.DW(DW), .TW(TW), .PERIOD(PERIOD)) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data[TW-1:0]),
        .rd_addr    (rd_addr),
        .width_i    (width_w),
        .temp_i     (temp_code),
        .run_o      (run_w),
        .rise_thr_o (rise_w),
        .fall_thr_o (fall_w),
        .width_wr_o (width_wr_w),
        .rd_data_o  (rd_data)
    );

    tstep_fan_step #(.DW(DW), .TW(TW), .PERIOD(PERIOD), .SETTLE_CYC(SETTLE_CYC)) step_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_w),
        .temp_i     (temp_code),
        .rise_thr_i (rise_w),
        .fall_thr_i (fall_w),
        .sw_wr_i    (width_wr_w),
        .sw_data_i  (wr_data),
        .width_o    (width_w),
        .level_o    (level_w),
        .ev_rise_o  (ev_temp_rise_o),
        .ev_chg_o   (ev_pwm_chg_o)
    );

    tstep_fan_pwm #(.DW(DW), .PERIOD(PERIOD)) pwm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_w),
        .width_i (width_w),
        .pwm_o   (pwm_o)
    );
endmodule

// File: rtl/tstep_fan_chk.sv
module tstep_fan_chk
    import tstep_fan_pkg::*;
#(
    parameter int DW     = 16,
    parameter int PERIOD = 2500
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input level_t        level,
    input logic [DW-1:0] width,
    input logic          pwm,
    input logic          ev_rise,
    input logic          ev_chg,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data
);
    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pwm);

    // R2
    period_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADR_PERIOD) |-> (rd_data == DW'(PERIOD)));

    // R3
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && width >= DW'(PERIOD)) |-> pwm);

    // R5
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVW'(NSTEP));

    // R6
    level_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$stable(level)) |-> ev_chg);

    // R6
    width_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$stable(width)) |-> ev_chg);

    // R7
    sw_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_en && wr_addr == ADR_WIDTH) |=> ev_chg);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_rise && ev_chg));

    // R9
    rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rise |=> !ev_rise);
endmodule

bind tstep_fan_ctrl tstep_fan_chk #(.DW(DW), .PERIOD(PERIOD)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_w),
    .level   (level_w),
    .width   (width_w),
    .pwm     (pwm_o),
    .ev_rise (ev_temp_rise_o),
    .ev_chg  (ev_pwm_chg_o),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/tstep_fan_ctrl_tb_top.sv
module tstep_fan_ctrl_tb_top;
    import tstep_fan_pkg::*;

    localparam int DW  = 16;
    localparam int TW  = 16;
    localparam int PER = 20;
    localparam int SET = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] temp_code = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          pwm_o, ev_rise, ev_chg;

    always #10 clk = ~clk;

    tstep_fan_ctrl #(.DW(DW), .TW(TW), .PERIOD(PER), .SETTLE_CYC(SET)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .temp_code      (temp_code),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .rd_addr        (rd_addr),
        .rd_data        (rd_data),
        .pwm_o          (pwm_o),
        .ev_temp_rise_o (ev_rise),
        .ev_pwm_chg_o   (ev_chg)
    );

    int     n_run = 0, n_fail = 0;
    longint cyc = 0, n_rise = 0, n_chg = 0, n_both = 0, t_rise = 0, t_chg = 0, hi_cnt = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ev_rise) begin n_rise <= n_rise + 1; t_rise <= cyc; end
        if (ev_chg)  begin n_chg  <= n_chg + 1;  t_chg  <= cyc; end
        if (ev_rise && ev_chg) n_both <= n_both + 1;
        if (pwm_o) hi_cnt <= hi_cnt + 1;
    end

    function automatic longint exp_w(input int lv);
        return (PER * lv) / 4;
    endfunction

    function automatic longint exp_duty(input longint w);
        return (w > PER) ? PER : w;
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input longint d);
        wr_en = 1'b1; wr_addr = a; wr_data = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output longint v);
        rd_addr = a;
        #1;
        v = longint'(rd_data);
    endtask

    task automatic duty(output longint h);
        longint h0;
        h0 = hi_cnt;
        tick(PER);
        h = hi_cnt - h0;
    endtask

    task automatic step_up(input int t, input int lv);
        longint r0, c0, v, h;
        r0 = n_rise; c0 = n_chg;
        temp_code = TW'(t);
        tick(SET + 4);
        check("R4", "rise strobe count", n_rise - r0, 1);
        check("R5", "change strobe count", n_chg - c0, 1);
        check("R5", "settle gap", t_chg - t_rise, SET);
        rd(ADR_WIDTH, v);
        check("R5", "stepped width", v, exp_w(lv));
        duty(h);
        check("R3", "stepped duty", h, exp_duty(exp_w(lv)));
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        longint v, h, r0, c0;
        void'($urandom(32'h5EED));
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1 / R2: reset state and map
        rd(ADR_RUN, v);    check("R1", "run after reset", v, 0);
        rd(ADR_WIDTH, v);  check("R2", "width after reset", v, 0);
        rd(ADR_PERIOD, v); check("R2", "period", v, PER);
        rd(ADR_RISE0 + 4'd2, v); check("R2", "rise reset", v, 16'hFFFF);
        rd(ADR_FALL0 + 4'd1, v); check("R2", "fall reset", v, 0);
        rd(4'd15, v);      check("R2", "unmapped read", v, 0);
        wr(ADR_PERIOD, 5);
        rd(ADR_PERIOD, v); check("R2", "period write ignored", v, PER);
        temp_code = 16'h1234;
        rd(ADR_TEMP, v);   check("R2", "temperature readback", v, 16'h1234);

        // R1: idle while run bit clear, width still writable
        temp_code = 16'd5000;
        wr(ADR_WIDTH, 12);
        tick(40);
        check("R1", "no rise while idle", n_rise, 0);
        check("R1", "no change while idle", n_chg, 0);
        duty(h);           check("R1", "idle output low", h, 0);
        rd(ADR_WIDTH, v);  check("R1", "idle width write lands", v, 12);
        wr(ADR_WIDTH, 0);

        // program thresholds
        for (int k = 0; k < 4; k++) begin
            wr(ADR_RISE0 + AW'(k), 1000 * (k + 1));
            wr(ADR_FALL0 + AW'(k), 1000 * k + 800);
        end
        rd(ADR_FALL0 + 4'd3, v); check("R2", "fall threshold readback", v, 3800);
        temp_code = 16'd1000;
        wr(ADR_RUN, 1);
        tick(SET + 4);
        check("R4", "equal temperature no rise", n_rise, 0);
        duty(h);           check("R3", "level 0 duty", h, 0);

        // R4/R5: step through all levels
        step_up(1001, 1);
        step_up(2500, 2);
        step_up(3500, 3);
        step_up(4500, 4);

        // R6: hysteresis hold and drops
        c0 = n_chg; r0 = n_rise;
        temp_code = 16'd3801; tick(30);
        temp_code = 16'd3800; tick(30);
        check("R6", "hold inside band", n_chg - c0, 0);
        check("R6", "no rise at top", n_rise - r0, 0);
        temp_code = 16'd3799; tick(3);
        check("R6", "single drop event", n_chg - c0, 1);
        rd(ADR_WIDTH, v);  check("R6", "width after drop", v, exp_w(3));
        c0 = n_chg;
        temp_code = 16'd500; tick(6);
        check("R6", "cascade drop events", n_chg - c0, 3);
        rd(ADR_WIDTH, v);  check("R6", "width at level 0", v, 0);

        // R8: write during settle cancels step
        r0 = n_rise; c0 = n_chg;
        temp_code = 16'd1500; tick(3);
        temp_code = 16'd900;
        wr(ADR_WIDTH, 7);
        tick(SET + 4);
        check("R8", "cancel rise count", n_rise - r0, 1);
        check("R8", "cancel change count", n_chg - c0, 1);
        rd(ADR_WIDTH, v);  check("R8", "cancel keeps sw width", v, 7);

        // R8: write lands on expiry edge
        r0 = n_rise; c0 = n_chg;
        temp_code = 16'd1500; tick(SET);
        temp_code = 16'd900;
        wr(ADR_WIDTH, 9);
        tick(SET + 4);
        check("R8", "collision rise count", n_rise - r0, 1);
        check("R8", "collision change count", n_chg - c0, 1);
        check("R8", "collision strobe timing", t_chg - t_rise, SET);
        rd(ADR_WIDTH, v);  check("R8", "collision sw width wins", v, 9);
        duty(h);           check("R3", "collision duty", h, 9);

        // R7/R3/R4: random widths at level 0 with random sub-threshold temps
        for (int i = 0; i < 16; i++) begin
            longint w;
            w = $urandom_range(0, PER + 10);
            temp_code = TW'($urandom_range(0, 1000));
            r0 = n_rise; c0 = n_chg;
            wr(ADR_WIDTH, w);
            tick(2);
            check("R7", "sw write strobe", n_chg - c0, 1);
            rd(ADR_WIDTH, v);  check("R7", "sw width readback", v, w);
            duty(h);           check("R3", "random duty", h, exp_duty(w));
            check("R4", "no rise below limit", n_rise - r0, 0);
        end

        // R1: clearing run stops the output
        wr(ADR_RUN, 0);
        r0 = n_rise;
        temp_code = 16'd5000;
        tick(30);
        check("R1", "no rise after stop", n_rise - r0, 0);
        duty(h);           check("R1", "output low after stop", h, 0);

        // R9
        check("R9", "strobes overlapping", n_both, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule